// File: doc/BRIEF.md
# Masked Pending-Interrupt Collector

This block gathers up to eight interrupt request lines into a pending register and drives one level-sensitive request toward the processor-side interrupt controller. Devices next to the block set pending bits with a one-cycle post vector and remove them with a one-cycle clear vector. Software works through a small byte-wide register bus. It writes an active-low mask, it acknowledges one line by giving that line's index, and it reads the pending byte back.

A second controller appears only as a stub. Its mask register accepts writes and keeps the value. Its acknowledge address accepts writes and does nothing. Its status address always reads as zero, and it never raises a request.

The bus takes one request per cycle. Read data and the error flag are registered and appear on the cycle after the request. Pending, enable and request state all update on the clock edge that accepts a write or a device vector.

Top module: `irq_mask_collector`

## Requirements
- R1: A synchronous reset clears the pending register, sets the enable vector to all zeros (every line masked), and drives `irq_o`, `bus_err` and `bus_rdata` to zero.
- R2: A byte write (size code 0) to address 1 stores the bitwise complement of the data as the enable vector, so a 1 written in bit i masks line i. Any other access leaves the enable vector unchanged.
- R3: From the edge after any change to pending or enable state, `irq_o` is 1 exactly when some pending bit is also enabled. This holds after a mask write, an acknowledge, a post or a clear.
- R4: Each 1 in `post_vec` sets the matching pending bit at the next edge. Existing pending bits stay set.
- R5: Each 1 in `clr_vec` clears the matching pending bit at the next edge. When `post_vec` and `clr_vec` both hit the same bit in one cycle, the bit ends up cleared.
- R6: A byte write to address 2 clears the pending bit whose index is in the low 4 bits of the data, and the upper data bits are ignored. An index from 8 to 15 clears nothing.
- R7: A byte read (size code 0) at address 0 returns, one cycle later, the pending byte as it was before that edge in `bus_rdata[7:0]`, with all upper bits zero.
- R8: An 8-byte read (size code 3) at address 0 returns the same pending byte zero-extended to 64 bits.
- R9: Byte writes to address 5 (secondary mask) and address 6 (secondary acknowledge) raise no error and change neither `irq_o` nor the pending register. A byte read at address 4 returns zero.
- R10: Every other access raises `bus_err` for one cycle, on the cycle after the request, and changes no state. This covers an unmapped address, a wrong direction, and a size other than those listed above. A later good access leaves `bus_err` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_size | input | 2 | Access size code: 0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 64 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | Registered one-cycle error flag for a rejected access |
| post_vec | input | 8 | Device set vector, ORed into pending |
| clr_vec | input | 8 | Device clear vector, removed from pending; beats post |
| irq_o | output | 1 | Level request: some enabled bit is pending |

## Verification
On every cycle, the embedded assertions check four things:
- the request level agrees with the pending and enable registers;
- a device clear always removes its bits, and a post that is not acknowledged always sets its bits;
- the enable vector and the secondary mask move only on their own writes;
- a rejected access is always followed by the error flag, and a secondary status read by zero data.

Some behaviour only the directed scenarios can show:
- the complement encoding of the mask;
- that the acknowledge index takes only the low nibble and ignores out-of-range values;
- the read-data timing and zero extension;
- that an erroneous access leaves the visible state alone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // access size codes on the bus
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_DWORD = 2'd3;

  // register addresses
  localparam int PRI_STAT_ADR = 0;
  localparam int PRI_MASK_ADR = 1;
  localparam int PRI_ACK_ADR  = 2;
  localparam int SEC_STAT_ADR = 4;
  localparam int SEC_MASK_ADR = 5;
  localparam int SEC_ACK_ADR  = 6;

  typedef struct packed {
    logic wr_mask;
    logic wr_ack;
    logic wr_smask;
    logic wr_sack;
    logic rd_pri;
    logic rd_sec;
    logic err;
  } irqc_cmd_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output irqc_cmd_t         cmd
);
  always_comb begin
    cmd = '0;
    if (valid) begin
      if (!write) begin
        if (addr == ADDR_W'(PRI_STAT_ADR) && (size == SZ_BYTE || size == SZ_DWORD))
          cmd.rd_pri = 1'b1;
        else if (addr == ADDR_W'(SEC_STAT_ADR) && size == SZ_BYTE)
          cmd.rd_sec = 1'b1;
        else
          cmd.err = 1'b1;
      end else if (size != SZ_BYTE) begin
        cmd.err = 1'b1;
      end else if (addr == ADDR_W'(PRI_MASK_ADR)) begin
        cmd.wr_mask = 1'b1;
      end else if (addr == ADDR_W'(PRI_ACK_ADR)) begin
        cmd.wr_ack = 1'b1;
      end else if (addr == ADDR_W'(SEC_MASK_ADR)) begin
        cmd.wr_smask = 1'b1;
      end else if (addr == ADDR_W'(SEC_ACK_ADR)) begin
        cmd.wr_sack = 1'b1;
      end else begin
        cmd.err = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int LINES = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] post_vec,
  input  logic [LINES-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [LINES-1:0] mask_data,
  input  logic             ack_we,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [LINES-1:0] pend_q,
  output logic             irq_q
);
  logic [LINES-1:0] en_q, en_d, pend_d, ack_vec;

  // one-hot decode of the acknowledge index; indices >= LINES hit nothing
  for (genvar i = 0; i < LINES; i++) begin : g_ack
    assign ack_vec[i] = ack_we && (ack_idx == IDX_W'(i));
  end

  always_comb begin
    pend_d = (pend_q | post_vec) & ~clr_vec & ~ack_vec;
    en_d   = mask_we ? ~mask_data : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= |(pend_d & en_d);
    end
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(pend_q & en_q)); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (|clr_vec) |=> ((pend_q & $past(clr_vec)) == '0)); // R5
  AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
    ((|post_vec) && !ack_we) |=>
      ((pend_q & $past(post_vec & ~clr_vec)) == $past(post_vec & ~clr_vec))); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((pend_q & $past(ack_vec & ~post_vec)) == '0)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(en_q)); // R2
endmodule

// File: rtl/irqc_sec_stub.sv
module irqc_sec_stub #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [LINES-1:0] mask_data
);
  logic [LINES-1:0] smask_q;

  always_ff @(posedge clk) begin
    if (rst)          smask_q <= '0;
    else if (mask_we) smask_q <= mask_data;
  end

  AST_SEC_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mask_we || ack_we) |=> $stable(smask_q)); // R9
endmodule

// File: rtl/irq_mask_collector.sv
module irq_mask_collector
  import irqc_pkg::*;
#(
  parameter int LINES   = 8,
  parameter int ADDR_W  = 4,
  parameter int IDX_W   = 4,
  parameter int RDATA_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [1:0]         bus_size,
  input  logic [LINES-1:0]   bus_wdata,
  output logic [RDATA_W-1:0] bus_rdata,
  output logic               bus_err,
  input  logic [LINES-1:0]   post_vec,
  input  logic [LINES-1:0]   clr_vec,
  output logic               irq_o
);
  irqc_cmd_t        cmd;
  logic [LINES-1:0] pend;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr),
    .size(bus_size), .cmd(cmd)
  );

  irqc_pending #(.LINES(LINES), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .post_vec(post_vec), .clr_vec(clr_vec),
    .mask_we(cmd.wr_mask), .mask_data(bus_wdata),
    .ack_we(cmd.wr_ack), .ack_idx(bus_wdata[IDX_W-1:0]),
    .pend_q(pend), .irq_q(irq_o)
  );

  irqc_sec_stub #(.LINES(LINES)) u_sec (
    .clk(clk), .rst(rst), .mask_we(cmd.wr_smask), .ack_we(cmd.wr_sack),
    .mask_data(bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= cmd.err;
      bus_rdata <= cmd.rd_pri ? RDATA_W'(pend) : '0;
    end
  end

  AST_SEC_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    cmd.rd_sec |=> (bus_rdata == '0)); // R9
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cmd.err |=> bus_err); // R10
  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (rst)
    !cmd.err |=> !bus_err); // R10
endmodule

// File: tb/irq_mask_collector_test.sv
`timescale 1ns/1ps
module irq_mask_collector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  post_vec = '0, clr_vec = '0;
  logic        irq_o;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_mask_collector uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .post_vec(post_vec),
    .clr_vec(clr_vec), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus access for one cycle; returns at the negedge after the accepting edge
  task automatic bus_op(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic dev_op(input logic [7:0] p, input logic [7:0] c);
    @(negedge clk);
    post_vec = p; clr_vec = c;
    @(negedge clk);
    post_vec = '0; clr_vec = '0;
  endtask

  task automatic read_pend(input string req, input logic [7:0] exp);
    bus_op(1'b0, 4'd0, 2'd0, 8'h00);
    chk(req, bus_rdata, {56'h0, exp});
  endtask

  task automatic t_reset;
    chk("R1 irq", irq_o, 0);
    chk("R1 err", bus_err, 0);
    chk("R1 rdata", bus_rdata, 0);
    read_pend("R1 pending", 8'h00);
  endtask

  task automatic t_post_masked;
    dev_op(8'h05, 8'h00);
    chk("R3 masked no irq", irq_o, 0);
    read_pend("R4 R7 pending after post", 8'h05);
  endtask

  task automatic t_mask;
    bus_op(1'b1, 4'd1, 2'd0, 8'hFE);
    chk("R2 R3 enable line0 irq", irq_o, 1);
    bus_op(1'b1, 4'd1, 2'd0, 8'hFF);
    chk("R2 R3 all masked irq", irq_o, 0);
    bus_op(1'b1, 4'd1, 2'd0, 8'h00);
    chk("R2 all enabled irq", irq_o, 1);
  endtask

  task automatic t_ack;
    bus_op(1'b1, 4'd2, 2'd0, 8'hF2);
    read_pend("R6 ack idx2 upper bits ignored", 8'h01);
    chk("R6 irq still up", irq_o, 1);
    bus_op(1'b1, 4'd2, 2'd0, 8'h09);
    read_pend("R6 ack idx9 no effect", 8'h01);
    bus_op(1'b1, 4'd2, 2'd0, 8'h00);
    chk("R6 R3 irq dropped after ack", irq_o, 0);
    read_pend("R6 pending empty", 8'h00);
  endtask

  task automatic t_post_clear;
    dev_op(8'h30, 8'h10);
    read_pend("R5 clear beats post", 8'h20);
    chk("R4 irq after post", irq_o, 1);
    dev_op(8'h00, 8'h20);
    chk("R5 R3 irq after clear", irq_o, 0);
    read_pend("R5 pending after clear", 8'h00);
  endtask

  task automatic t_dword;
    dev_op(8'h81, 8'h00);
    bus_op(1'b0, 4'd0, 2'd3, 8'h00);
    chk("R8 dword read", bus_rdata, 64'h81);
    chk("R8 no err", bus_err, 0);
  endtask

  task automatic t_secondary;
    bus_op(1'b1, 4'd5, 2'd0, 8'h00);
    chk("R9 smask no err", bus_err, 0);
    chk("R9 smask irq unchanged", irq_o, 1);
    bus_op(1'b1, 4'd6, 2'd0, 8'h00);
    chk("R9 sack no err", bus_err, 0);
    read_pend("R9 sack pending unchanged", 8'h81);
    bus_op(1'b0, 4'd4, 2'd0, 8'h00);
    chk("R9 sec status zero", bus_rdata, 0);
  endtask

  task automatic t_errors;
    bus_op(1'b0, 4'd3, 2'd0, 8'h00);
    chk("R10 unmapped read err", bus_err, 1);
    @(negedge clk);
    chk("R10 err one cycle", bus_err, 0);
    bus_op(1'b1, 4'd0, 2'd0, 8'hFF);
    chk("R10 write to status err", bus_err, 1);
    bus_op(1'b1, 4'd1, 2'd1, 8'hFF);
    chk("R10 half mask write err", bus_err, 1);
    chk("R10 R2 mask unchanged", irq_o, 1);
    bus_op(1'b1, 4'd2, 2'd3, 8'h00);
    chk("R10 dword ack err", bus_err, 1);
    bus_op(1'b0, 4'd0, 2'd1, 8'h00);
    chk("R10 half read err", bus_err, 1);
    read_pend("R10 pending unchanged", 8'h81);
    chk("R10 good access clears err", bus_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_post_masked();
    t_mask();
    t_ack();
    t_post_clear();
    t_dword();
    t_secondary();
    t_errors();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule